// File: doc/BRIEF.md
# Video Sync Input Conditioner

This block takes the raw horizontal and vertical sync lines of a video digitizer and turns them into clean, active-high strobes in the pixel clock domain. Each line first crosses a two-flop synchronizer. It then gets its own polarity correction. An optional three-sample majority filter follows, selected per line by a control bit.

The vertical strobe is also qualified by a minimum width. A vertical pulse is only passed on once it has stayed active for a programmed number of consecutive pixel clocks. Shorter pulses never reach the output.

All settings are static inputs. They are changed only while reset is held. The horizontal output carries one extra register, so that both strobes leave the block with the same delay when the width threshold is 0 or 1.

Top module: `sync_cond_top`

## Requirements
- R1: A level on a sync input sampled at rising edge n appears on the matching output after edge n+3 when its filter is off; both inputs pass a two-flop synchronizer first.
- R2: With cfg_hs_invert = 0, a high hs_raw is the active level; with cfg_hs_invert = 1, a low hs_raw is the active level; hs_clean is always active high.
- R3: cfg_vs_invert selects the active level of vs_raw with the same encoding (0 = high active, 1 = low active); vs_clean is always active high.
- R4: With cfg_hs_filt_en = 1, the horizontal path outputs the majority of three consecutive corrected samples. This adds exactly 2 clocks of delay and removes isolated one-sample glitches. With 0 the filter is bypassed.
- R5: cfg_vs_filt_en controls the same majority filter on the vertical path, with the same encoding and delay.
- R6: Let W = cfg_vs_min_width, with W ≥ 1. Let the conditioned vertical sync first become active from the sample at edge n. vs_clean then rises after edge n+2+W if the pulse lasts at least W clocks, and never rises if it is shorter. vs_clean falls 3 edges after the first inactive input sample.
- R7: W = 0 and W = 1 reject no vertical pulse, including single-clock pulses.
- R8: The width counter saturates at 255, so W = 255 passes pulses of 255 clocks or more and holds vs_clean high for their full length.
- R9: While rst_n is low at a rising edge, both outputs are 0 from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hs_raw | input | 1 | Raw horizontal sync, asynchronous |
| vs_raw | input | 1 | Raw vertical sync, asynchronous |
| cfg_vs_min_width | input | 8 | Minimum vertical pulse width in pixel clocks |
| cfg_hs_invert | input | 1 | 1 = horizontal input is active low |
| cfg_hs_filt_en | input | 1 | 1 = majority filter on horizontal path |
| cfg_vs_invert | input | 1 | 1 = vertical input is active low |
| cfg_vs_filt_en | input | 1 | 1 = majority filter on vertical path |
| hs_clean | output | 1 | Conditioned active-high horizontal strobe |
| vs_clean | output | 1 | Conditioned, width-qualified vertical strobe |

## Verification
The output delays are fixed: 3 edges after the sampling edge with the filter off, 5 with it on, and 2+W edges for a qualified vertical rise. The bench keeps a queue of corrected input samples per line. It reads the due sample at the matching queue depth and keeps its own run count for the width rule. Every clock it compares both outputs on the falling edge, after the design's registers have settled. Comparisons pause for a short window after each reset release, while the synchronizers fill with the idle level.

// File: rtl/sync_cond_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the sync conditioner.
// Assumes exactly two sync channels, horizontal at index 0 and vertical at index 1.
package sync_cond_pkg;
    localparam int NUM_CH = 2;
    localparam int IDX_HS = 0;
    localparam int IDX_VS = 1;

    // Per-channel static configuration
    typedef struct packed {
        logic invert;   // 1 = input is active low
        logic filt_en;  // 1 = route through majority filter
    } chan_cfg_t;
endpackage

// File: rtl/sync_cdc.sv
`timescale 1ns/1ps
// Multi-flop synchronizer that brings an asynchronous level into the clk domain.
// Assumes STAGES >= 2; resets to 0.
module sync_cdc #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sync_chan.sv
`timescale 1ns/1ps
// One sync channel: polarity correction, optional majority vote over TAPS
// consecutive samples, and a registered active-high output.
// Assumes din is already synchronized and TAPS is odd and >= 3.
module sync_chan
    import sync_cond_pkg::*;
#(
    parameter int TAPS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      din,
    input  chan_cfg_t cfg,
    output logic      cond
);
    localparam int CW   = $clog2(TAPS + 1);
    localparam int HALF = TAPS / 2;

    logic            pol;
    logic [TAPS-1:0] hist_q;
    logic [CW-1:0]   ones;
    logic            vote;
    logic            cond_q;

    // Polarity correction: active level becomes 1
    assign pol = din ^ cfg.invert;

    // Sample history for the voter
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[TAPS-2:0], pol};
    end

    // Count active samples in the history window
    always_comb begin
        ones = '0;
        for (int i = 0; i < TAPS; i++) ones = ones + CW'(hist_q[i]);
    end

    assign vote = (ones > CW'(HALF));

    // Output register, selecting filtered or bypassed level
    always_ff @(posedge clk) begin
        if (!rst_n) cond_q <= 1'b0;
        else        cond_q <= cfg.filt_en ? vote : pol;
    end

    assign cond = cond_q;

    // R4 R5: a filtered rise needs the newest history sample to be active
    filt_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cond_q) && $past(cfg.filt_en)) |-> $past(hist_q[0]));
endmodule

// File: rtl/vs_qual.sv
`timescale 1ns/1ps
// Minimum-width qualifier for the conditioned vertical sync.
// Counts consecutive active clocks, saturating at the counter maximum, and
// passes the pulse once the run reaches min_w. Assumes min_w is static outside reset.
module vs_qual #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_in,
    input  logic [CNT_W-1:0] min_w,
    output logic             vs_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] run;
    logic             out_q;

    // Run length including the current sample, saturating
    always_comb begin
        if (!vs_in)                run = '0;
        else if (cnt_q == CNT_MAX) run = CNT_MAX;
        else                       run = cnt_q + 1'b1;
    end

    // Run counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= run;
    end

    // Qualified output register
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= vs_in && (run >= min_w);
    end

    assign vs_out = out_q;

    // R6
    vs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_out |-> $past(vs_in));
    // R6
    vs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vs_out |-> (cnt_q >= min_w));
    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < $past(cnt_q)) |-> (cnt_q == '0));
    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == CNT_MAX && $past(vs_in)) |-> (cnt_q == CNT_MAX));
endmodule

// File: rtl/sync_cond_top.sv
`timescale 1ns/1ps
// Video sync input conditioner top. Synchronizes, polarity-corrects and
// optionally filters both sync lines, then width-qualifies the vertical one.
// Assumes configuration changes only while rst_n is low.
module sync_cond_top
    import sync_cond_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_raw,
    input  logic             vs_raw,
    input  logic [CNT_W-1:0] cfg_vs_min_width,
    input  logic             cfg_hs_invert,
    input  logic             cfg_hs_filt_en,
    input  logic             cfg_vs_invert,
    input  logic             cfg_vs_filt_en,
    output logic             hs_clean,
    output logic             vs_clean
);
    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] synced;
    logic [NUM_CH-1:0] cond;
    chan_cfg_t         cfg_a [NUM_CH];
    logic              hs_q;

    assign raw_in[IDX_HS] = hs_raw;
    assign raw_in[IDX_VS] = vs_raw;

    // Gather per-channel settings
    always_comb begin
        cfg_a[IDX_HS] = '{invert: cfg_hs_invert, filt_en: cfg_hs_filt_en};
        cfg_a[IDX_VS] = '{invert: cfg_vs_invert, filt_en: cfg_vs_filt_en};
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        sync_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .dout (synced[g])
        );
        sync_chan #(.TAPS(FILT_TAPS)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (synced[g]),
            .cfg  (cfg_a[g]),
            .cond (cond[g])
        );
    end

    // Delay-match register for the horizontal path
    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= 1'b0;
        else        hs_q <= cond[IDX_HS];
    end

    assign hs_clean = hs_q;

    vs_qual #(.CNT_W(CNT_W)) u_vsq (
        .clk   (clk),
        .rst_n (rst_n),
        .vs_in (cond[IDX_VS]),
        .min_w (cfg_vs_min_width),
        .vs_out(vs_clean)
    );
endmodule

// File: tb/sim_sync_cond_top.sv
`timescale 1ns/1ps
module sim_sync_cond_top;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       hs_raw = 1'b0, vs_raw = 1'b0;
    logic [7:0] cfg_w = 8'd0;
    logic       hinv = 0, hfilt = 0, vinv = 0, vfilt = 0;
    logic       hs_clean, vs_clean;

    sync_cond_top u0 (
        .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .vs_raw(vs_raw),
        .cfg_vs_min_width(cfg_w), .cfg_hs_invert(hinv), .cfg_hs_filt_en(hfilt),
        .cfg_vs_invert(vinv), .cfg_vs_filt_en(vfilt),
        .hs_clean(hs_clean), .vs_clean(vs_clean)
    );

    int    total = 0, bad = 0;
    bit    done = 0;
    string cur_req = "R9";

    // Reference model state
    bit hq[$], vq[$];
    bit hc_prev, vc_prev, exp_hs, exp_vs;
    int vrun, rst_edges, live_edges;

    function automatic bit maj3(bit a, bit b, bit c);
        return (a & b) | (a & c) | (b & c);
    endfunction

    // Behavioural model: corrected samples queued per edge, index 0 newest
    always @(posedge clk) begin
        bit hc, vc;
        if (!rst_n) begin
            hq.delete(); vq.delete();
            for (int i = 0; i < 8; i++) begin hq.push_front(1'b0); vq.push_front(1'b0); end
            hc_prev = 0; vc_prev = 0; vrun = 0; exp_hs = 0; exp_vs = 0;
            rst_edges++; live_edges = 0;
        end else begin
            rst_edges = 0; live_edges++;
            hq.push_front(hs_raw ^ hinv); void'(hq.pop_back());
            vq.push_front(vs_raw ^ vinv); void'(vq.pop_back());
            exp_hs = hc_prev;
            exp_vs = vc_prev && (vrun >= int'(cfg_w));
            hc = hfilt ? maj3(hq[3], hq[4], hq[5]) : hq[2];
            vc = vfilt ? maj3(vq[3], vq[4], vq[5]) : vq[2];
            vrun = vc ? ((vrun >= 255) ? 255 : vrun + 1) : 0;
            hc_prev = hc; vc_prev = vc;
        end
    end

    task automatic check(string tag, string what, logic act, bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare on every falling edge
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n && rst_edges >= 1) begin
                check("R9", "hs_clean in reset", hs_clean, 1'b0);
                check("R9", "vs_clean in reset", vs_clean, 1'b0);
            end else if (rst_n && live_edges >= 12) begin
                check(cur_req, "hs_clean", hs_clean, exp_hs);
                check(cur_req, "vs_clean", vs_clean, exp_vs);
            end
        end
    end

    task automatic restart(string tag, logic [7:0] w, logic hi, logic hf, logic vi, logic vf);
        rst_n = 0; cfg_w = w; hinv = hi; hfilt = hf; vinv = vi; vfilt = vf;
        hs_raw = hi; vs_raw = vi; cur_req = tag;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (14) @(negedge clk);
    endtask

    task automatic drive(bit h, bit v, int n);
        hs_raw = h ^ hinv; vs_raw = v ^ vinv;
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses();
        drive(1, 1, 1); drive(0, 0, 6);
        drive(1, 0, 2); drive(0, 0, 6);
        drive(1, 1, 3); drive(0, 0, 6);
        drive(1, 0, 1); drive(0, 0, 1); drive(1, 0, 1); drive(0, 0, 6);
        drive(0, 1, 2); drive(0, 0, 1); drive(1, 1, 4); drive(0, 0, 6);
        for (int k = 1; k <= 9; k++) begin drive(1, 1, k); drive(0, 0, 8); end
        for (int k = 0; k < 6; k++) begin drive(1, 1, 1); drive(0, 0, 1); end
        drive(0, 0, 8);
    endtask

    task automatic scramble(int n);
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[3], lfsr[5] & lfsr[7] | lfsr[9], 1);
        end
        drive(0, 0, 10);
    endtask

    initial begin
        @(negedge clk);
        // R9: reset state
        restart("R9", 8'd0, 0, 0, 0, 0);
        // R1: bypass timing, both lines positive
        cur_req = "R1"; pulses();
        // R2: horizontal active low
        restart("R2", 8'd0, 1, 0, 0, 0); pulses();
        // R3: vertical active low
        restart("R3", 8'd0, 0, 0, 1, 0); pulses();
        // R4: horizontal majority filter
        restart("R4", 8'd0, 0, 1, 0, 0); pulses();
        restart("R4", 8'd0, 1, 1, 0, 0); pulses();
        // R5: vertical majority filter
        restart("R5", 8'd0, 0, 0, 0, 1); pulses();
        restart("R5", 8'd0, 0, 0, 1, 1); pulses();
        // R6: width qualification
        restart("R6", 8'd5, 0, 0, 0, 0); pulses();
        restart("R6", 8'd4, 0, 1, 1, 1); pulses();
        restart("R6", 8'd12, 0, 0, 0, 0);
        for (int k = 10; k <= 14; k++) begin drive(0, 1, k); drive(0, 0, 5); end
        // R7: zero and one thresholds pass everything
        restart("R7", 8'd0, 0, 0, 0, 0); pulses();
        restart("R7", 8'd1, 0, 0, 1, 0); pulses();
        // R8: saturation
        restart("R8", 8'd255, 0, 0, 0, 0);
        drive(0, 1, 254); drive(0, 0, 6);
        drive(0, 1, 255); drive(0, 0, 6);
        drive(0, 1, 300); drive(0, 0, 6);
        restart("R8", 8'd200, 0, 0, 0, 1);
        drive(0, 1, 600); drive(0, 0, 3); drive(0, 1, 199); drive(0, 0, 8);
        // R1: mixed scrambled traffic over several settings
        restart("R1", 8'd0, 0, 0, 0, 0); scramble(1500);
        restart("R1", 8'd3, 1, 1, 0, 1); scramble(1500);
        restart("R1", 8'd2, 0, 1, 1, 0); scramble(1500);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1; total++; bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule